// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory and watches the select, address and write strobe of each port. When both ports are selected and point at the same location, it decides which port arrived later and drives that port's active-low busy line. The port that was already settled on the location keeps its busy line inactive. Both busy lines are never active together. Arrival order is judged once per clock edge. A port whose select and address were already held in the previous cycle counts as the earlier one. When both ports arrive in the same cycle, the left port wins.

The block has two modes. In master mode it drives both busy lines as ordinary push-pull outputs. In slave mode the busy lines of a master arbiter come in on separate inputs. They are used only to block writes, and the block's own busy outputs stay inactive. In both modes the block produces a per-port write qualifier. The memory commits a write only when that qualifier is high. A port that is losing a collision therefore never writes, whatever its strobe does.

Top module: `dpa_collision_arb`

## Requirements
- R1: With both ports selected (select low) at different addresses, both busy outputs are high on the cycle after the inputs are sampled.
- R2: With either port deselected (select high), both busy outputs are high on the cycle after sampling, even when the two addresses are equal.
- R3: In master mode, when both ports are selected at an equal address and only one of them held its select and address unchanged since the previous edge, the other port's busy output goes low after the edge that samples the collision. The earlier port's busy output stays high.
- R4: In master mode, when neither port (or both ports) held its select and address since the previous edge at the start of a collision, the right busy output goes low and the left stays high.
- R5: The two busy outputs are never low at the same time.
- R6: While the collision inputs stay unchanged, the busy output stays low. It returns high after the first edge that samples a changed address or a deselected port.
- R7: In master mode, a port's write qualifier is high only when that port is selected, its write strobe is low, and it is neither busy nor about to become the loser of a collision. A port that is losing a collision gets no write qualifier, including the cycle before its busy output falls.
- R8: In slave mode, both busy outputs are high. A low busy input blocks that port's write qualifier, and the block's internal arbitration has no effect on the qualifiers.
- R9: After synchronous active-low reset, both busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1: arbiter drives busy; 0: busy taken from inputs |
| left_sel_n | input | 1 | Left port select, active low |
| left_addr | input | ADDR_W | Left port address |
| left_wr_n | input | 1 | Left port write strobe, active low |
| right_sel_n | input | 1 | Right port select, active low |
| right_addr | input | ADDR_W | Right port address |
| right_wr_n | input | 1 | Right port write strobe, active low |
| left_busy_n_i | input | 1 | Left busy from a master arbiter (slave mode) |
| right_busy_n_i | input | 1 | Right busy from a master arbiter (slave mode) |
| left_busy_n_o | output | 1 | Left busy, active low, push-pull |
| right_busy_n_o | output | 1 | Right busy, active low, push-pull |
| left_wr_ok | output | 1 | Left write may be committed to memory |
| right_wr_ok | output | 1 | Right write may be committed to memory |

## Verification
The arbiter holds only a one-cycle history per port and a registered loser code. A corrupted loser code therefore shows at the busy outputs on the very next cycle. It shows either as a busy line on the port that arrived first, or as a busy line that stays low after the collision ends. A wrong history register swaps the arrival verdict of the next collision, which makes the wrong port busy one cycle after that collision is sampled. A fault in the write qualifiers shows at once, in the same cycle, as a qualifier that is high while its port's busy line is low or about to fall.

// File: rtl/dpa_pkg.sv
// Shared types for the dual-port collision arbiter.
// Assumes exactly two ports, indexed left = 0 and right = 1.
package dpa_pkg;
    localparam int NUM_PORTS = 2;
    localparam int PORT_L    = 0;
    localparam int PORT_R    = 1;

    // Which port, if any, currently loses a collision.
    typedef enum logic [1:0] {
        LOSE_NONE  = 2'd0,
        LOSE_LEFT  = 2'd1,
        LOSE_RIGHT = 2'd2
    } loser_e;
endpackage

// File: rtl/dpa_port_track.sv
// Per-port history tracker.
// It keeps the select and address of the previous cycle. It reports "stable" when the
// port is selected now and was selected at the same address one edge ago.
// Assumes select is active low and the reset is synchronous and active low.
module dpa_port_track #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              sel,
    output logic              stable
);
    logic              prev_sel;
    logic [ADDR_W-1:0] prev_addr;

    // Decode the active-low select into a positive flag.
    always_comb sel = ~sel_n;

    // Remember last cycle's select and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sel  <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_sel  <= sel;
            prev_addr <= addr;
        end
    end

    // The port counts as settled when its selection and address did not move.
    always_comb stable = sel && prev_sel && (prev_addr == addr);
endmodule

// File: rtl/dpa_judge.sv
// Collision judge.
// It decides which port loses an address collision and registers that verdict.
// The verdict is held for as long as both ports keep their select and address.
// A new collision goes against the port that arrived later. A tie goes against the right port.
module dpa_judge
    import dpa_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] sel,
    input  logic [NUM_PORTS-1:0] stable,
    input  logic                 addr_eq,
    output loser_e               loser_q,
    output loser_e               loser_nxt
);
    logic match_now;

    // A collision exists when both ports are selected at one address.
    always_comb match_now = sel[PORT_L] && sel[PORT_R] && addr_eq;

    // Next verdict: hold it, pick the later arrival, or break the tie to the left.
    always_comb begin
        if (!match_now) begin
            loser_nxt = LOSE_NONE;
        end else if (stable[PORT_L] && stable[PORT_R]) begin
            loser_nxt = loser_q;
        end else if (stable[PORT_L]) begin
            loser_nxt = LOSE_RIGHT;
        end else if (stable[PORT_R]) begin
            loser_nxt = LOSE_LEFT;
        end else begin
            loser_nxt = LOSE_RIGHT;
        end
    end

    // Register the verdict; reset means nobody is busy.
    always_ff @(posedge clk) begin
        if (!rst_n) loser_q <= LOSE_NONE;
        else        loser_q <= loser_nxt;
    end
endmodule

// File: rtl/dpa_write_gate.sv
// Per-port write qualifier.
// In master mode a write is refused while the port is busy or is about to lose a collision.
// In slave mode only the incoming busy line counts.
module dpa_write_gate (
    input  logic master_mode,
    input  logic sel_n,
    input  logic wr_n,
    input  logic busy_own,
    input  logic lose_soon,
    input  logic busy_n_in,
    output logic wr_ok
);
    logic req;
    logic block;

    // A write request needs both select and strobe low.
    always_comb req = ~sel_n & ~wr_n;

    // Choose the blocking source according to the mode.
    always_comb block = master_mode ? (busy_own | lose_soon) : ~busy_n_in;

    // Pass the write only when nothing blocks it.
    always_comb wr_ok = req & ~block;
endmodule

// File: rtl/dpa_collision_arb.sv
// Dual-port address collision arbiter, top level.
// It tracks both ports, judges collisions, drives push-pull busy lines in master mode and
// qualifies writes in both modes. In slave mode its busy outputs stay inactive.
module dpa_collision_arb
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              left_sel_n,
    input  logic [ADDR_W-1:0] left_addr,
    input  logic              left_wr_n,
    input  logic              right_sel_n,
    input  logic [ADDR_W-1:0] right_addr,
    input  logic              right_wr_n,
    input  logic              left_busy_n_i,
    input  logic              right_busy_n_i,
    output logic              left_busy_n_o,
    output logic              right_busy_n_o,
    output logic              left_wr_ok,
    output logic              right_wr_ok
);
    logic [NUM_PORTS-1:0] sel_n_v;
    logic [NUM_PORTS-1:0] wr_n_v;
    logic [NUM_PORTS-1:0] busy_in_v;
    logic [ADDR_W-1:0]    addr_v [NUM_PORTS];
    logic [NUM_PORTS-1:0] sel_v;
    logic [NUM_PORTS-1:0] stable_v;
    logic [NUM_PORTS-1:0] busy_own_v;
    logic [NUM_PORTS-1:0] lose_soon_v;
    logic [NUM_PORTS-1:0] wr_ok_v;
    logic                 addr_eq;
    loser_e               loser_q;
    loser_e               loser_nxt;

    // Gather the port pins into vectors indexed by port.
    always_comb begin
        sel_n_v[PORT_L]   = left_sel_n;
        sel_n_v[PORT_R]   = right_sel_n;
        wr_n_v[PORT_L]    = left_wr_n;
        wr_n_v[PORT_R]    = right_wr_n;
        busy_in_v[PORT_L] = left_busy_n_i;
        busy_in_v[PORT_R] = right_busy_n_i;
        addr_v[PORT_L]    = left_addr;
        addr_v[PORT_R]    = right_addr;
    end

    // Compare the two addresses.
    always_comb addr_eq = (left_addr == right_addr);

    // Decode the verdicts into per-port flags.
    always_comb begin
        busy_own_v[PORT_L]  = (loser_q   == LOSE_LEFT);
        busy_own_v[PORT_R]  = (loser_q   == LOSE_RIGHT);
        lose_soon_v[PORT_L] = (loser_nxt == LOSE_LEFT);
        lose_soon_v[PORT_R] = (loser_nxt == LOSE_RIGHT);
    end

    genvar g;
    generate
        for (g = 0; g < NUM_PORTS; g++) begin : g_port
            dpa_port_track #(.ADDR_W(ADDR_W)) track_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .sel_n  (sel_n_v[g]),
                .addr   (addr_v[g]),
                .sel    (sel_v[g]),
                .stable (stable_v[g])
            );
            dpa_write_gate gate_i (
                .master_mode (master_mode),
                .sel_n       (sel_n_v[g]),
                .wr_n        (wr_n_v[g]),
                .busy_own    (busy_own_v[g]),
                .lose_soon   (lose_soon_v[g]),
                .busy_n_in   (busy_in_v[g]),
                .wr_ok       (wr_ok_v[g])
            );
        end
    endgenerate

    dpa_judge judge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel_v),
        .stable    (stable_v),
        .addr_eq   (addr_eq),
        .loser_q   (loser_q),
        .loser_nxt (loser_nxt)
    );

    // Drive the busy outputs only in master mode; they are inactive high otherwise.
    always_comb begin
        left_busy_n_o  = ~(master_mode & busy_own_v[PORT_L]);
        right_busy_n_o = ~(master_mode & busy_own_v[PORT_R]);
        left_wr_ok     = wr_ok_v[PORT_L];
        right_wr_ok    = wr_ok_v[PORT_R];
    end
endmodule

// File: rtl/dpa_collision_arb_chk.sv
// Assertion checker for the collision arbiter, attached by bind.
// It observes only the top-level ports.
module dpa_collision_arb_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              left_sel_n,
    input logic [ADDR_W-1:0] left_addr,
    input logic              left_wr_n,
    input logic              right_sel_n,
    input logic [ADDR_W-1:0] right_addr,
    input logic              right_wr_n,
    input logic              left_busy_n_i,
    input logic              right_busy_n_i,
    input logic              left_busy_n_o,
    input logic              right_busy_n_o,
    input logic              left_wr_ok,
    input logic              right_wr_ok
);
    // R5
    never_both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!left_busy_n_o && !right_busy_n_o));

    // R1 R2
    no_collision_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_sel_n || right_sel_n || (left_addr != right_addr)) |=> (left_busy_n_o && right_busy_n_o));

    // R3
    left_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !left_sel_n && !right_sel_n && (left_addr == right_addr)
         && !$past(left_sel_n) && ($past(left_addr) == left_addr)
         && ($past(right_sel_n) || ($past(right_addr) != right_addr)))
        |=> (!right_busy_n_o && left_busy_n_o));

    // R4
    tie_right_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !left_sel_n && !right_sel_n && (left_addr == right_addr)
         && $past(left_sel_n) && $past(right_sel_n))
        |=> (!right_busy_n_o && left_busy_n_o));

    // R7
    left_busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !left_busy_n_o) |-> !left_wr_ok);

    // R7
    right_busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !right_busy_n_o) |-> !right_wr_ok);

    // R7
    write_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_wr_ok |-> (!left_sel_n && !left_wr_n)) and (right_wr_ok |-> (!right_sel_n && !right_wr_n)));

    // R8
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (left_busy_n_o && right_busy_n_o));

    // R8
    slave_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && (!left_busy_n_i || !right_busy_n_i))
        |-> ((left_busy_n_i || !left_wr_ok) && (right_busy_n_i || !right_wr_ok)));
endmodule

bind dpa_collision_arb dpa_collision_arb_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .master_mode    (master_mode),
    .left_sel_n     (left_sel_n),
    .left_addr      (left_addr),
    .left_wr_n      (left_wr_n),
    .right_sel_n    (right_sel_n),
    .right_addr     (right_addr),
    .right_wr_n     (right_wr_n),
    .left_busy_n_i  (left_busy_n_i),
    .right_busy_n_i (right_busy_n_i),
    .left_busy_n_o  (left_busy_n_o),
    .right_busy_n_o (right_busy_n_o),
    .left_wr_ok     (left_wr_ok),
    .right_wr_ok    (right_wr_ok)
);

// File: tb/dpa_collision_arb_tb.sv
// Directed bench for the collision arbiter: one task per scenario.
module dpa_collision_arb_tb_top;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_mode = 1'b1;
    logic          left_sel_n = 1'b1, right_sel_n = 1'b1;
    logic [AW-1:0] left_addr = '0, right_addr = '0;
    logic          left_wr_n = 1'b1, right_wr_n = 1'b1;
    logic          left_busy_n_i = 1'b1, right_busy_n_i = 1'b1;
    logic          left_busy_n_o, right_busy_n_o, left_wr_ok, right_wr_ok;

    int n_checks = 0;
    int n_fail   = 0;

    dpa_collision_arb #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .left_sel_n(left_sel_n), .left_addr(left_addr), .left_wr_n(left_wr_n),
        .right_sel_n(right_sel_n), .right_addr(right_addr), .right_wr_n(right_wr_n),
        .left_busy_n_i(left_busy_n_i), .right_busy_n_i(right_busy_n_i),
        .left_busy_n_o(left_busy_n_o), .right_busy_n_o(right_busy_n_o),
        .left_wr_ok(left_wr_ok), .right_wr_ok(right_wr_ok)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance one edge, then let registered outputs settle.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(input logic ls, input logic [AW-1:0] la, input logic lw,
                         input logic rs, input logic [AW-1:0] ra, input logic rw);
        left_sel_n = ls; left_addr = la; left_wr_n = lw;
        right_sel_n = rs; right_addr = ra; right_wr_n = rw;
        #1;
    endtask

    task automatic idle();
        drive(1'b1, '0, 1'b1, 1'b1, '0, 1'b1);
        tick();
        tick();
    endtask

    // Every cycle: no double busy, no write from a busy port (R5, R7).
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5", "both busy low", {30'd0, left_busy_n_o, right_busy_n_o} == 32'd0, 32'd0);
            if (master_mode) begin
                chk("R7", "left write while busy", !left_busy_n_o && left_wr_ok, 32'd0);
                chk("R7", "right write while busy", !right_busy_n_o && right_wr_ok, 32'd0);
            end
        end
    end

    task automatic t_reset();
        rst_n = 1'b0;
        drive(1'b0, 14'h0100, 1'b1, 1'b0, 14'h0100, 1'b1);
        tick();
        chk("R9", "left busy in reset", left_busy_n_o, 1);
        chk("R9", "right busy in reset", right_busy_n_o, 1);
        drive(1'b1, '0, 1'b1, 1'b1, '0, 1'b1);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R9", "left busy after reset", left_busy_n_o, 1);
        chk("R9", "right busy after reset", right_busy_n_o, 1);
    endtask

    task automatic t_no_match();
        idle();
        drive(1'b0, 14'h0A00, 1'b0, 1'b0, 14'h0A01, 1'b0);
        chk("R7", "left write distinct", left_wr_ok, 1);
        chk("R7", "right write distinct", right_wr_ok, 1);
        tick();
        chk("R1", "left busy distinct", left_busy_n_o, 1);
        chk("R1", "right busy distinct", right_busy_n_o, 1);
        drive(1'b0, 14'h3FFF, 1'b1, 1'b0, 14'h0000, 1'b1);
        tick();
        chk("R1", "left busy far apart", left_busy_n_o, 1);
        chk("R1", "right busy far apart", right_busy_n_o, 1);
    endtask

    task automatic t_deselect();
        idle();
        drive(1'b1, 14'h0055, 1'b0, 1'b0, 14'h0055, 1'b0);
        tick();
        chk("R2", "left busy, left off", left_busy_n_o, 1);
        chk("R2", "right busy, left off", right_busy_n_o, 1);
        chk("R2", "right write, left off", right_wr_ok, 1);
        drive(1'b0, 14'h0055, 1'b0, 1'b1, 14'h0055, 1'b0);
        tick();
        chk("R2", "left busy, right off", left_busy_n_o, 1);
        chk("R2", "right busy, right off", right_busy_n_o, 1);
    endtask

    task automatic t_left_first();
        idle();
        drive(1'b0, 14'h1234, 1'b1, 1'b1, 14'h0000, 1'b1);
        tick();
        drive(1'b0, 14'h1234, 1'b1, 1'b0, 14'h1234, 1'b0);
        chk("R7", "right write before busy falls", right_wr_ok, 0);
        chk("R3", "left busy before edge", left_busy_n_o, 1);
        tick();
        chk("R3", "right busy after left first", right_busy_n_o, 0);
        chk("R3", "left busy after left first", left_busy_n_o, 1);
        chk("R7", "right write while losing", right_wr_ok, 0);
        drive(1'b0, 14'h1234, 1'b0, 1'b0, 14'h1234, 1'b0);
        chk("R7", "winner left writes", left_wr_ok, 1);
        tick();
        tick();
        chk("R6", "right busy held", right_busy_n_o, 0);
        drive(1'b0, 14'h1234, 1'b1, 1'b1, 14'h1234, 1'b1);
        chk("R6", "right busy until edge", right_busy_n_o, 0);
        tick();
        chk("R6", "right busy released", right_busy_n_o, 1);
        chk("R6", "left busy released", left_busy_n_o, 1);
    endtask

    task automatic t_right_first();
        idle();
        drive(1'b1, 14'h0000, 1'b1, 1'b0, 14'h2222, 1'b1);
        tick();
        drive(1'b0, 14'h2222, 1'b0, 1'b0, 14'h2222, 1'b0);
        chk("R7", "left write before busy falls", left_wr_ok, 0);
        chk("R7", "right winner writes", right_wr_ok, 1);
        tick();
        chk("R3", "left busy after right first", left_busy_n_o, 0);
        chk("R3", "right busy after right first", right_busy_n_o, 1);
        drive(1'b0, 14'h2223, 1'b0, 1'b0, 14'h2222, 1'b0);
        tick();
        chk("R6", "left busy released on address move", left_busy_n_o, 1);
        chk("R1", "right busy after address move", right_busy_n_o, 1);
    endtask

    task automatic t_tie();
        idle();
        drive(1'b0, 14'h0777, 1'b0, 1'b0, 14'h0777, 1'b0);
        chk("R7", "left tie winner writes", left_wr_ok, 1);
        chk("R7", "right tie loser blocked", right_wr_ok, 0);
        tick();
        chk("R4", "right busy on tie", right_busy_n_o, 0);
        chk("R4", "left busy on tie", left_busy_n_o, 1);
        // Both ports jump together to a new shared address: a fresh tie.
        drive(1'b0, 14'h0778, 1'b1, 1'b0, 14'h0778, 1'b1);
        tick();
        chk("R4", "right busy on moved tie", right_busy_n_o, 0);
        chk("R4", "left busy on moved tie", left_busy_n_o, 1);
    endtask

    task automatic t_slave();
        idle();
        master_mode = 1'b0;
        left_busy_n_i = 1'b0;
        right_busy_n_i = 1'b1;
        drive(1'b0, 14'h0300, 1'b0, 1'b0, 14'h0300, 1'b0);
        chk("R8", "slave left blocked by input", left_wr_ok, 0);
        chk("R8", "slave right allowed", right_wr_ok, 1);
        tick();
        chk("R8", "slave left busy out", left_busy_n_o, 1);
        chk("R8", "slave right busy out", right_busy_n_o, 1);
        chk("R8", "slave right still allowed", right_wr_ok, 1);
        left_busy_n_i = 1'b1;
        right_busy_n_i = 1'b0;
        #1;
        chk("R8", "slave left allowed", left_wr_ok, 1);
        chk("R8", "slave right blocked by input", right_wr_ok, 0);
        right_busy_n_i = 1'b1;
        master_mode = 1'b1;
        idle();
    endtask

    initial begin : watchdog
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_no_match();
        t_deselect();
        t_left_first();
        t_right_first();
        t_tie();
        t_slave();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule